// File: doc/BRIEF.md
# Reset and Mode-Select Pin Controller

This block sets the function of two shared pins on a small microcontroller. It works from two option bits and from the device's reset state. Pin A starts out as a plain general-purpose input. Software can turn it into an active-low external reset input. Once turned on, that function stays on until the next reset. The pin's pull-up is forced on while the reset function is active.

Pin B has three roles:
- While the device is held in reset, it is a mode-select input.
- At the moment reset is released, its level is latched into a background-mode flag.
- After release, it serves the debug function with its pull-up on, or, once its enable bit is cleared, it becomes an output-only port pin.

Reset has two sources: the asynchronous power-on reset and a filtered external request from pin A. The block stretches either one into an internal reset of fixed length. Every option bit returns to its default whenever that internal reset is active.

Top module: `rmp_pinctl`

## Requirements
- R1: While power-on reset is active, and right after it, the option read-back `opt_rdata_o` reads 2'b10. Bit 0 is the reset-pin enable and reads 0. Bit 1 is the debug-pin enable and reads 1. In this state pin A is a general-purpose input whose pull-up follows `pina_pue_i`.
- R2: An option write with bit 0 set turns on the reset-pin enable. While the enable is set, a write with bit 0 clear leaves it set. Bit 1 takes the written value on every option write.
- R3: While the reset-pin enable is set, `pina_pu_o` is 1 whatever `pina_pue_i` is.
- R4: Pin A passes through a 2-flop synchroniser. With the reset-pin enable set, the synchronised level must be low for MIN_LOW (2) consecutive clocks to start an internal reset. A pad low from one negedge to the negedge two clocks later drops `rst_n_o` after the fourth rising edge. A pad low for only one clock does not drop `rst_n_o`. Pin A held low while the enable is clear does not drop `rst_n_o`.
- R5: An internal reset keeps `rst_n_o` low for RST_HOLD (4) clocks. It clears the reset-pin enable and sets the debug-pin enable back to 1.
- R6: While `rst_n_o` is low, pin B is an input with its pull-up on (`pinb_oe_o`=0, `pinb_pu_o`=1). Option writes during that time are ignored.
- R7: At the clock edge where `rst_n_o` rises, `bgnd_o` takes the inverse of `pinb_pad_i`. A low pin selects background mode (`bgnd_o`=1). `bgnd_o` then holds its value until the next reset, whatever pin B does.
- R8: With the debug-pin enable at 1 and out of reset, pin B has `pinb_oe_o`=0, `pinb_pu_o`=1 and `pinb_do_o`=0.
- R9: With the debug-pin enable at 0 and out of reset, pin B has `pinb_oe_o`=1, `pinb_pu_o`=0, and `pinb_do_o` follows `pinb_dat_i`.
- R10: Power-on reset drives `rst_n_o` low at once. `rst_n_o` rises at the fourth rising edge after `por_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 2 | Option write data: bit 0 reset-pin enable, bit 1 debug-pin enable |
| opt_rdata_o | output | 2 | Option read-back, same bit layout |
| pina_pad_i | input | 1 | Pin A pad level |
| pina_pue_i | input | 1 | General pull-up setting for pin A |
| pina_pu_o | output | 1 | Pin A pull-up enable |
| pinb_pad_i | input | 1 | Pin B pad level |
| pinb_dat_i | input | 1 | Port data for pin B in output-only use |
| pinb_oe_o | output | 1 | Pin B output enable |
| pinb_do_o | output | 1 | Pin B output data |
| pinb_pu_o | output | 1 | Pin B pull-up enable |
| rst_n_o | output | 1 | Internal reset, active low |
| bgnd_o | output | 1 | Latched background-mode flag |

## Verification
A wrong value in the sticky enable shows up within one clock: the read-back changes and pin A's pull-up changes with it. A wrong filter count shows up as `rst_n_o` falling one clock early or late, or as a one-clock glitch starting a reset. Either is seen within four edges of the pad stimulus. A bad hold counter moves the rising edge of `rst_n_o`. Because the mode flag is captured on that same edge, a wrong capture, or a flag that later drifts, is visible on `bgnd_o` from the first clock after release.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
    localparam int OPT_W         = 2;
    localparam int OPT_RSTEN_BIT = 0;
    localparam int OPT_DBGEN_BIT = 1;

    typedef struct packed {
        logic rsten;
        logic dbgen;
    } opt_t;

    localparam opt_t OPT_DEFAULT = '{rsten: 1'b0, dbgen: 1'b1};

    typedef enum logic [1:0] {
        PB_MODESEL = 2'd0,
        PB_DEBUG   = 2'd1,
        PB_OUTPUT  = 2'd2
    } pinb_fn_e;
endpackage

// File: rtl/rmp_rst_filter.sv
module rmp_rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic en_i,
    input  logic pad_i,
    output logic trig_o
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(MIN_LOW - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
    } flt_t;

    flt_t st_d, st_q;
    logic low_seen;

    always_comb begin
        st_d     = st_q;
        low_seen = ~st_q.sync[SYNC_STAGES-1];
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pad_i};
        trig_o   = en_i && low_seen && (st_q.cnt == LAST_CNT);
        if (en_i && low_seen && !trig_o) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.sync <= '1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rmp_rst_seq.sv
module rmp_rst_seq #(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig_i,
    input  logic mode_pin_i,
    output logic in_rst_o,
    output logic bgnd_o
);
    localparam int HW = $clog2(RST_HOLD + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(RST_HOLD);
    localparam logic [HW-1:0] HOLD_LAST = HW'(1);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic          bgnd;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.hold = HOLD_LOAD;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
            if (st_q.hold == HOLD_LAST) begin
                st_d.bgnd = ~mode_pin_i;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.hold <= HOLD_LOAD;
            st_q.bgnd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_rst_o = (st_q.hold != '0);
    assign bgnd_o   = st_q.bgnd;
endmodule

// File: rtl/rmp_pinctl.sv
module rmp_pinctl
    import rmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2,
    parameter int RST_HOLD    = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             opt_we,
    input  logic [OPT_W-1:0] opt_wdata,
    output logic [OPT_W-1:0] opt_rdata_o,
    input  logic             pina_pad_i,
    input  logic             pina_pue_i,
    output logic             pina_pu_o,
    input  logic             pinb_pad_i,
    input  logic             pinb_dat_i,
    output logic             pinb_oe_o,
    output logic             pinb_do_o,
    output logic             pinb_pu_o,
    output logic             rst_n_o,
    output logic             bgnd_o
);
    opt_t     opt_d, opt_q;
    pinb_fn_e pb_fn;
    logic     trig;
    logic     in_rst;

    rmp_rst_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_LOW    (MIN_LOW)
    ) u_filter (
        .clk   (clk),
        .por_n (por_n),
        .en_i  (opt_q.rsten),
        .pad_i (pina_pad_i),
        .trig_o(trig)
    );

    rmp_rst_seq #(
        .RST_HOLD(RST_HOLD)
    ) u_seq (
        .clk       (clk),
        .por_n     (por_n),
        .trig_i    (trig),
        .mode_pin_i(pinb_pad_i),
        .in_rst_o  (in_rst),
        .bgnd_o    (bgnd_o)
    );

    always_comb begin
        opt_d = opt_q;
        if (in_rst || trig) begin
            opt_d = OPT_DEFAULT;
        end else if (opt_we) begin
            opt_d.rsten = opt_q.rsten | opt_wdata[OPT_RSTEN_BIT];
            opt_d.dbgen = opt_wdata[OPT_DBGEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            opt_q <= OPT_DEFAULT;
        end else begin
            opt_q <= opt_d;
        end
    end

    always_comb begin
        if (in_rst) begin
            pb_fn = PB_MODESEL;
        end else if (opt_q.dbgen) begin
            pb_fn = PB_DEBUG;
        end else begin
            pb_fn = PB_OUTPUT;
        end
        unique case (pb_fn)
            PB_OUTPUT: begin
                pinb_oe_o = 1'b1;
                pinb_pu_o = 1'b0;
                pinb_do_o = pinb_dat_i;
            end
            default: begin
                pinb_oe_o = 1'b0;
                pinb_pu_o = 1'b1;
                pinb_do_o = 1'b0;
            end
        endcase
    end

    always_comb begin
        opt_rdata_o                = '0;
        opt_rdata_o[OPT_RSTEN_BIT] = opt_q.rsten;
        opt_rdata_o[OPT_DBGEN_BIT] = opt_q.dbgen;
    end

    assign pina_pu_o = opt_q.rsten | pina_pue_i;
    assign rst_n_o   = ~in_rst;
endmodule

// File: rtl/rmp_pinctl_chk.sv
module rmp_pinctl_chk (
    input logic       clk,
    input logic       por_n,
    input logic [1:0] opt_rdata_o,
    input logic       pina_pu_o,
    input logic       pinb_pad_i,
    input logic       pinb_oe_o,
    input logic       pinb_pu_o,
    input logic       rst_n_o,
    input logic       bgnd_o
);
    logic rsten, dbgen;
    assign rsten = opt_rdata_o[0];
    assign dbgen = opt_rdata_o[1];

    // R2
    rsten_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n_o && rsten) |=> (rsten || !rst_n_o));

    // R3
    rstpin_pullup_chk: assert property (@(posedge clk) disable iff (!por_n)
        rsten |-> pina_pu_o);

    // R5
    rst_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_n_o) |-> (!rsten && dbgen));

    // R6
    modesel_pin_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n_o |-> (!pinb_oe_o && pinb_pu_o));

    // R7
    mode_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> (bgnd_o == !$past(pinb_pad_i)));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_n_o |=> (!rst_n_o || $stable(bgnd_o)));

    // R9
    out_port_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n_o && !dbgen) |-> (pinb_oe_o && !pinb_pu_o));
endmodule

bind rmp_pinctl rmp_pinctl_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .opt_rdata_o(opt_rdata_o),
    .pina_pu_o  (pina_pu_o),
    .pinb_pad_i (pinb_pad_i),
    .pinb_oe_o  (pinb_oe_o),
    .pinb_pu_o  (pinb_pu_o),
    .rst_n_o    (rst_n_o),
    .bgnd_o     (bgnd_o)
);

// File: tb/rmp_pinctl_bench.sv
module rmp_pinctl_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       opt_we = 1'b0;
    logic [1:0] opt_wdata = 2'b00;
    logic [1:0] opt_rdata_o;
    logic       pina_pad_i = 1'b1;
    logic       pina_pue_i = 1'b0;
    logic       pina_pu_o;
    logic       pinb_pad_i = 1'b1;
    logic       pinb_dat_i = 1'b0;
    logic       pinb_oe_o, pinb_do_o, pinb_pu_o, rst_n_o, bgnd_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rmp_pinctl u_rmp_pinctl (
        .clk        (clk),
        .por_n      (por_n),
        .opt_we     (opt_we),
        .opt_wdata  (opt_wdata),
        .opt_rdata_o(opt_rdata_o),
        .pina_pad_i (pina_pad_i),
        .pina_pue_i (pina_pue_i),
        .pina_pu_o  (pina_pu_o),
        .pinb_pad_i (pinb_pad_i),
        .pinb_dat_i (pinb_dat_i),
        .pinb_oe_o  (pinb_oe_o),
        .pinb_do_o  (pinb_do_o),
        .pinb_pu_o  (pinb_pu_o),
        .rst_n_o    (rst_n_o),
        .bgnd_o     (bgnd_o)
    );

    // {we, wd_rsten, wd_dbgen, pue, dat, exp pina_pu, oe, do, pinb_pu, rsten, dbgen}
    localparam logic [10:0] VEC [8] = '{
        11'b00000_000101,
        11'b00010_100101,
        11'b10001_011000,
        11'b00000_010000,
        11'b10100_000101,
        11'b11100_100111,
        11'b10001_111010,
        11'b11110_100111
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(2);
        // R10 R6 R1 while power-on reset is held
        chk("R10 rst low during por", 8'(rst_n_o), 8'd0);
        chk("R6 pinb input pull-up in reset", 8'({pinb_oe_o, pinb_pu_o}), 8'b01);
        chk("R1 option defaults", 8'(opt_rdata_o), 8'b10);
        por_n = 1'b1;
        step(3);
        chk("R10 rst still low", 8'(rst_n_o), 8'd0);
        step(1);
        chk("R10 rst released", 8'(rst_n_o), 8'd1);
        chk("R7 high pin gives normal mode", 8'(bgnd_o), 8'd0);
        chk("R1 defaults after release", 8'(opt_rdata_o), 8'b10);

        // Vector walk: R1 R2 R3 R8 R9
        for (int i = 0; i < 8; i++) begin
            {opt_we, opt_wdata[0], opt_wdata[1], pina_pue_i, pinb_dat_i} = VEC[i][10:6];
            step(1);
            opt_we = 1'b0;
            step(1);
            chk($sformatf("R3 R1 pina pull-up vec%0d", i), 8'(pina_pu_o), 8'(VEC[i][5]));
            chk($sformatf("R8 R9 pinb pins vec%0d", i),
                8'({pinb_oe_o, pinb_do_o, pinb_pu_o}), 8'(VEC[i][4:2]));
            chk($sformatf("R2 option readback vec%0d", i),
                8'({opt_rdata_o[0], opt_rdata_o[1]}), 8'(VEC[i][1:0]));
        end
        pina_pue_i = 1'b0;

        // R4 one-clock glitch ignored
        pina_pad_i = 1'b0;
        step(1);
        pina_pad_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            step(1);
            chk("R4 glitch ignored", 8'(rst_n_o), 8'd1);
        end
        chk("R4 enable kept after glitch", 8'(opt_rdata_o[0]), 8'd1);

        // R4 R5 two-clock low pulse starts reset
        pinb_pad_i = 1'b0;
        pina_pad_i = 1'b0;
        step(2);
        pina_pad_i = 1'b1;
        step(1);
        chk("R4 no reset before filter done", 8'(rst_n_o), 8'd1);
        step(1);
        chk("R4 reset asserted", 8'(rst_n_o), 8'd0);
        chk("R6 pinb modesel in ext reset", 8'({pinb_oe_o, pinb_pu_o}), 8'b01);
        opt_we = 1'b1;
        opt_wdata = 2'b01;
        step(1);
        opt_we = 1'b0;
        step(2);
        chk("R5 reset held", 8'(rst_n_o), 8'd0);
        step(1);
        chk("R5 reset released after hold", 8'(rst_n_o), 8'd1);
        chk("R7 low pin gives background mode", 8'(bgnd_o), 8'd1);
        chk("R5 R6 options defaulted, write ignored", 8'(opt_rdata_o), 8'b10);

        // R7 flag holds while pin moves
        pinb_pad_i = 1'b1;
        step(3);
        pinb_pad_i = 1'b0;
        step(1);
        pinb_pad_i = 1'b1;
        step(1);
        chk("R7 flag held", 8'(bgnd_o), 8'd1);

        // R4 pin low with enable clear
        pina_pad_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step(1);
            chk("R4 disabled pin ignored", 8'(rst_n_o), 8'd1);
        end
        pina_pad_i = 1'b1;

        // R10 second power-on reset, pin B high
        por_n = 1'b0;
        #1;
        chk("R10 async assert", 8'(rst_n_o), 8'd0);
        step(2);
        por_n = 1'b1;
        step(4);
        chk("R10 rst released after por", 8'(rst_n_o), 8'd1);
        chk("R7 normal mode recaptured", 8'(bgnd_o), 8'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule